// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Generator

This block produces addresses for indirect memory accesses. It holds NSETS register sets. Each set has four AW-bit registers: an index (the pointer), a modify (a signed step), a length and a base. There are two full copies of these sets, and the `bank_sel` control picks which copy is active. Software loads and inspects the registers through a plain write port and a combinational read port. Both ports address the active copy.

An access request selects one set for the index, length and base, and one set for the modify. It also carries two mode bits: pre-modify and bit-reverse.

- A post-modify access emits the current index and writes back the stepped index.
- A pre-modify access emits the stepped value and leaves the index unchanged.

When the length is non-zero, the stepped value wraps so that it stays inside the buffer from base to base+length-1. The buffer may have any base and any length. When the bit-reverse mode is set, the emitted address has its bits mirrored.

Requests enter on a valid/ready stream and addresses leave on a valid/ready stream through a one-entry output register. A request is taken when `acc_valid` and `acc_ready` are both high at a clock edge. `acc_ready` is high when the output register is empty, or when it is being drained in that cycle. While `out_valid` is high and `out_ready` is low, the output holds its address unchanged and no new request is taken.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset every register in both copies reads zero and `out_valid` is low.
- R2: The register port selects a register with `wr_kind`/`rd_kind`, encoded 0=index, 1=modify, 2=length, 3=base. A value written to any of the NSETS sets reads back unchanged on `rd_data`.
- R3: Writing a base register also loads the index register of the same set with the written value.
- R4: `bank_sel` (0 or 1) chooses the register copy used by the register port and by accesses. The other copy keeps its contents.
- R5: A post-modify access emits the old index one cycle after it is taken. It writes index+modify back, with modify read as two's complement; with length zero no wrap is applied.
- R6: With non-zero length, a stepped value at or above base+length has the length subtracted.
- R7: With non-zero length, a stepped value below base has the length added.
- R8: A pre-modify access (`acc_pre`=1) emits index+modify, wrapped as in R6/R7, and leaves the index unchanged.
- R9: With `acc_brev`=1 the emitted address is mirrored: bit k of the chosen value appears at bit AW-1-k.
- R10: While `out_valid` is high and `out_ready` is low, `out_addr` stays stable and `acc_ready` is low. A taken request always yields `out_valid` on the next cycle.
- R11: When a register write to an index (or to the base) and a post-modify update of the same index happen in the same cycle, the register write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bank_sel | input | 1 | Active register copy |
| wr_en | input | 1 | Register write strobe |
| wr_set | input | $clog2(NSETS) | Set written |
| wr_kind | input | 2 | Register written (0 index, 1 modify, 2 length, 3 base) |
| wr_data | input | AW | Write value |
| rd_set | input | $clog2(NSETS) | Set read |
| rd_kind | input | 2 | Register read |
| rd_data | output | AW | Read value (combinational) |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request taken when high with valid |
| acc_iset | input | $clog2(NSETS) | Set giving index, length, base |
| acc_mset | input | $clog2(NSETS) | Set giving modify |
| acc_pre | input | 1 | 1 = pre-modify, 0 = post-modify |
| acc_brev | input | 1 | 1 = bit-reversed output |
| out_valid | output | 1 | Address valid |
| out_ready | input | 1 | Consumer accepts address |
| out_addr | output | AW | Generated address |

## Verification
The bench builds the block with its defaults, AW=32 and NSETS=8. At this width, bit reversal moves low index bits to the top of the word, so a small index gives an address such as 0x80000000. A negative modify, written as a full 32-bit two's-complement value, exercises the downward wrap. Eight sets leave room to keep the linear, circular, negative-step and bit-reverse buffers apart, each with its own state. Back-pressure is applied by holding `out_ready` low while a second request waits.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [1:0] {
    RK_INDEX  = 2'd0,
    RK_MODIFY = 2'd1,
    RK_LENGTH = 2'd2,
    RK_BASE   = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/dag_regbank.sv
module dag_regbank
  import dag_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NSETS = 8,
  localparam int SW   = $clog2(NSETS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bank,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_set,
  input  reg_kind_e     wr_kind,
  input  logic [AW-1:0] wr_data,
  input  logic [SW-1:0] rd_set,
  input  reg_kind_e     rd_kind,
  output logic [AW-1:0] rd_data,
  input  logic [SW-1:0] a_iset,
  input  logic [SW-1:0] a_mset,
  output logic [AW-1:0] a_idx,
  output logic [AW-1:0] a_mod,
  output logic [AW-1:0] a_len,
  output logic [AW-1:0] a_base,
  input  logic          upd_en,
  input  logic [SW-1:0] upd_set,
  input  logic [AW-1:0] upd_val
);
  localparam int NB = 2;

  logic [AW-1:0] r_idx  [NB][NSETS];
  logic [AW-1:0] r_mod  [NB][NSETS];
  logic [AW-1:0] r_len  [NB][NSETS];
  logic [AW-1:0] r_base [NB][NSETS];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    for (genvar s = 0; s < NSETS; s++) begin : g_set
      logic hit_wr, hit_upd;
      assign hit_wr  = wr_en && (bank == 1'(b)) && (wr_set == SW'(s));
      assign hit_upd = upd_en && (bank == 1'(b)) && (upd_set == SW'(s));

      always_ff @(posedge clk) begin
        if (rst) begin
          r_idx[b][s]  <= '0;
          r_mod[b][s]  <= '0;
          r_len[b][s]  <= '0;
          r_base[b][s] <= '0;
        end else begin
          if (hit_wr && wr_kind == RK_MODIFY) r_mod[b][s]  <= wr_data;
          if (hit_wr && wr_kind == RK_LENGTH) r_len[b][s]  <= wr_data;
          if (hit_wr && wr_kind == RK_BASE)   r_base[b][s] <= wr_data;
          if (hit_wr && (wr_kind == RK_INDEX || wr_kind == RK_BASE))
            r_idx[b][s] <= wr_data;
          else if (hit_upd)
            r_idx[b][s] <= upd_val;
        end
      end
    end
  end

  always_comb begin
    unique case (rd_kind)
      RK_INDEX:  rd_data = r_idx[bank][rd_set];
      RK_MODIFY: rd_data = r_mod[bank][rd_set];
      RK_LENGTH: rd_data = r_len[bank][rd_set];
      default:   rd_data = r_base[bank][rd_set];
    endcase
  end

  assign a_idx  = r_idx[bank][a_iset];
  assign a_mod  = r_mod[bank][a_mset];
  assign a_len  = r_len[bank][a_iset];
  assign a_base = r_base[bank][a_iset];
endmodule

// File: rtl/dag_wrap.sv
module dag_wrap #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] mdf,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] bse,
  output logic [AW-1:0] stepped
);
  localparam int EW = AW + 2;

  logic signed [EW-1:0] sum, lo, hi, ext_len;

  always_comb begin
    ext_len = signed'({2'b00, len});
    sum     = signed'({2'b00, idx}) + signed'({{2{mdf[AW-1]}}, mdf});
    lo      = signed'({2'b00, bse});
    hi      = lo + ext_len;
    if (len == '0)
      stepped = sum[AW-1:0];
    else if (sum >= hi)
      stepped = AW'(sum - ext_len);
    else if (sum < lo)
      stepped = AW'(sum + ext_len);
    else
      stepped = sum[AW-1:0];
  end
endmodule

// File: rtl/dag_out_stage.sv
module dag_out_stage #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic          in_brev,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr
);
  logic [AW-1:0] mirrored, chosen;

  for (genvar k = 0; k < AW; k++) begin : g_rev
    assign mirrored[AW-1-k] = in_addr[k];
  end

  assign chosen   = in_brev ? mirrored : in_addr;
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_addr <= chosen;
    end
  end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import dag_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NSETS = 8,
  localparam int SW   = $clog2(NSETS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bank_sel,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_set,
  input  logic [1:0]    wr_kind,
  input  logic [AW-1:0] wr_data,
  input  logic [SW-1:0] rd_set,
  input  logic [1:0]    rd_kind,
  output logic [AW-1:0] rd_data,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic [SW-1:0] acc_iset,
  input  logic [SW-1:0] acc_mset,
  input  logic          acc_pre,
  input  logic          acc_brev,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr
);
  logic [AW-1:0] a_idx, a_mod, a_len, a_base, nxt_idx, emit;
  logic          taken;

  assign taken = acc_valid && acc_ready;
  assign emit  = acc_pre ? nxt_idx : a_idx;

  dag_regbank #(.AW(AW), .NSETS(NSETS)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .bank    (bank_sel),
    .wr_en   (wr_en),
    .wr_set  (wr_set),
    .wr_kind (reg_kind_e'(wr_kind)),
    .wr_data (wr_data),
    .rd_set  (rd_set),
    .rd_kind (reg_kind_e'(rd_kind)),
    .rd_data (rd_data),
    .a_iset  (acc_iset),
    .a_mset  (acc_mset),
    .a_idx   (a_idx),
    .a_mod   (a_mod),
    .a_len   (a_len),
    .a_base  (a_base),
    .upd_en  (taken && !acc_pre),
    .upd_set (acc_iset),
    .upd_val (nxt_idx)
  );

  dag_wrap #(.AW(AW)) u_wrap (
    .idx     (a_idx),
    .mdf     (a_mod),
    .len     (a_len),
    .bse     (a_base),
    .stepped (nxt_idx)
  );

  dag_out_stage #(.AW(AW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (acc_valid),
    .in_ready  (acc_ready),
    .in_addr   (emit),
    .in_brev   (acc_brev),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr)
  );
endmodule

// File: rtl/dag_checker.sv
module dag_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_valid,
  input logic          acc_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic [AW-1:0] cur_i,
  input logic [AW-1:0] cur_m,
  input logic [AW-1:0] cur_l,
  input logic [AW-1:0] cur_b,
  input logic [AW-1:0] nxt
);
  localparam int CW = AW + 2;

  logic [CW-1:0] lo, hi, ie, ne, mag, le;
  logic          in_win, fits, step_ok, nxt_in;

  always_comb begin
    lo      = {2'b00, cur_b};
    le      = {2'b00, cur_l};
    hi      = lo + le;
    ie      = {2'b00, cur_i};
    ne      = {2'b00, nxt};
    mag     = cur_m[AW-1] ? {2'b00, -cur_m} : {2'b00, cur_m};
    fits    = hi <= {2'b01, {AW{1'b0}}};
    in_win  = (cur_l != '0) && fits && (ie >= lo) && (ie < hi);
    step_ok = mag <= le;
    nxt_in  = (ne >= lo) && (ne < hi);
  end

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (in_win && step_ok && !cur_m[AW-1]) |-> nxt_in); // R6

  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (in_win && step_ok && cur_m[AW-1]) |-> nxt_in); // R7

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr))); // R10

  AST_STALL_IN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !acc_ready); // R10

  AST_TAKE_EMIT: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_ready) |=> out_valid); // R10
endmodule

bind circ_addr_gen dag_checker #(.AW(AW)) u_dag_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .acc_ready (acc_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .cur_i     (a_idx),
  .cur_m     (a_mod),
  .cur_l     (a_len),
  .cur_b     (a_base),
  .nxt       (nxt_idx)
);

// File: tb/test_circ_addr_gen.sv
module test_circ_addr_gen;
  localparam int AW = 32;
  localparam int NSETS = 8;
  localparam int SW = $clog2(NSETS);

  logic clk = 0, rst = 1;
  logic bank_sel = 0, wr_en = 0, acc_valid = 0, acc_pre = 0, acc_brev = 0, out_ready = 1;
  logic [SW-1:0] wr_set = '0, rd_set = '0, acc_iset = '0, acc_mset = '0;
  logic [1:0] wr_kind = '0, rd_kind = '0;
  logic [AW-1:0] wr_data = '0;
  logic [AW-1:0] rd_data, out_addr;
  logic acc_ready, out_valid;

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] exp_q[$];

  always #5 clk = ~clk;

  circ_addr_gen #(.AW(AW), .NSETS(NSETS)) i_circ_addr_gen (.*);

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected addresses as the design hands them out
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) chk("R10 unexpected output", out_addr, 'x);
      else chk("R5/R6/R7/R8/R9 address", out_addr, exp_q.pop_front());
    end
  end

  task automatic wr(input int s, input int k, input logic [AW-1:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_set = SW'(s); wr_kind = 2'(k); wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input string req, input int s, input int k, input logic [AW-1:0] exp);
    rd_set = SW'(s); rd_kind = 2'(k); #1;
    chk(req, rd_data, exp);
  endtask

  task automatic acc(input int is, input int ms, input logic pre, input logic brev,
                     input logic [AW-1:0] exp);
    exp_q.push_back(exp);
    @(posedge clk); #1;
    acc_valid = 1; acc_iset = SW'(is); acc_mset = SW'(ms); acc_pre = pre; acc_brev = brev;
    do @(negedge clk); while (!acc_ready);
    @(posedge clk); #1;
    acc_valid = 0;
  endtask

  task automatic drain;
    int guard = 0;
    while (exp_q.size() != 0 && guard < 50) begin @(posedge clk); guard++; end
    chk("R10 queue drained", AW'(exp_q.size()), '0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state, both copies
    @(negedge clk);
    chk("R1 out_valid", AW'(out_valid), '0);
    for (int b = 0; b < 2; b++) begin
      bank_sel = b[0];
      for (int s = 0; s < NSETS; s++)
        for (int k = 0; k < 4; k++) rd("R1 reg zero", s, k, '0);
    end
    bank_sel = 0;

    // R2 write/readback, kind 0=index 1=modify 2=length 3=base
    wr(0, 0, 100); wr(0, 1, 4); wr(7, 2, 32'hDEADBEEF);
    rd("R2 index", 0, 0, 100); rd("R2 modify", 0, 1, 4); rd("R2 length set7", 7, 2, 32'hDEADBEEF);
    // R3 base write loads index
    wr(1, 3, 32'h200);
    rd("R3 index follows base", 1, 0, 32'h200);
    wr(1, 2, 10); wr(1, 1, 3);

    // R5 linear post-modify
    acc(0, 0, 0, 0, 100); acc(0, 0, 0, 0, 104);
    drain(); rd("R5 index stepped", 0, 0, 108);

    // R6 upward wrap: 0x200..0x209, base 0x200 len 10 step 3
    acc(1, 1, 0, 0, 32'h200); acc(1, 1, 0, 0, 32'h203);
    acc(1, 1, 0, 0, 32'h206); acc(1, 1, 0, 0, 32'h209);
    acc(1, 1, 0, 0, 32'h202);
    drain(); rd("R6 wrapped index", 1, 0, 32'h205);

    // R7 downward wrap: base 0x300 len 7 step -3
    wr(2, 3, 32'h300); wr(2, 2, 7); wr(2, 1, 32'hFFFFFFFD);
    acc(2, 2, 0, 0, 32'h300); acc(2, 2, 0, 0, 32'h304);
    drain(); rd("R7 wrapped index", 2, 0, 32'h301);

    // R8 pre-modify, linear and circular; index unchanged
    acc(0, 0, 1, 0, 112); acc(1, 1, 1, 0, 32'h208);
    drain(); rd("R8 index kept set0", 0, 0, 108); rd("R8 index kept set1", 1, 0, 32'h205);

    // R9 bit reverse: 1 -> bit31, 2 -> bit30, pre 3+1=4 -> bit29
    wr(3, 3, 1); wr(3, 1, 1);
    acc(3, 3, 0, 1, 32'h80000000); acc(3, 3, 0, 1, 32'h40000000);
    acc(3, 3, 1, 1, 32'h20000000);
    drain(); rd("R9 index after brev", 3, 0, 3);

    // R4 second copy independent
    @(posedge clk); #1 bank_sel = 1;
    rd("R4 other copy empty", 0, 0, 0);
    wr(0, 0, 32'h55);
    acc(0, 0, 0, 0, 32'h55);
    drain(); rd("R4 other copy index", 0, 0, 32'h55);
    @(posedge clk); #1 bank_sel = 0;
    rd("R4 first copy kept", 0, 0, 108);

    // R11 write beats same-cycle update
    exp_q.push_back(108);
    @(posedge clk); #1;
    acc_valid = 1; acc_iset = 0; acc_mset = 0; acc_pre = 0; acc_brev = 0;
    wr_en = 1; wr_set = 0; wr_kind = 0; wr_data = 32'h900;
    @(negedge clk); chk("R11 ready", AW'(acc_ready), 1);
    @(posedge clk); #1 acc_valid = 0; wr_en = 0;
    drain(); rd("R11 write wins", 0, 0, 32'h900);

    // R10 back-pressure
    @(posedge clk); #1 out_ready = 0;
    acc(0, 0, 0, 0, 32'h900);
    exp_q.push_back(32'h904);
    @(posedge clk); #1 acc_valid = 1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R10 ready low", AW'(acc_ready), 0);
      chk("R10 valid held", AW'(out_valid), 1);
      chk("R10 addr held", out_addr, 32'h900);
    end
    @(posedge clk); #1 out_ready = 1;
    @(posedge clk); #1 acc_valid = 0;
    drain(); rd("R10 index after stall", 0, 0, 32'h908);

    finish_run();
  end
endmodule